// File: doc/BRIEF.md
# If-Then Predication Tracker

This block tracks a short run of predicated instructions opened by an if-then instruction. The decoder gives it a base condition code, a then/else choice for each slot after the first, and the number of instructions covered (one to four). While the run is in progress, the block uses the current N, Z, C and V flags to decide whether the instruction in the current slot executes or is skipped. Each retire pulse moves it to the next slot. After the final slot retires, the block falls idle.

The tracker keeps its whole context in an 8-bit word. This word can be read at any time and written back, so an interrupt handler can save a run that is half done and resume it later. The word holds a 4-bit condition code for the current slot and a 4-bit slot mask. Reading the mask from the most significant bit down, it holds the condition low bits of the remaining slots, then a single terminating 1, then zeros. Each advance shifts the mask left by one place. The run closes when an advance finds the mask equal to binary 1000.

Inside, a small controller has three states. IDLE means no run is open. RUN means a run is open with more slots to come. LAST means the current slot is the final one. The controller moves as follows:
- IDLE to RUN or LAST when an open is accepted.
- RUN to RUN or LAST when a slot retires.
- LAST to IDLE when the final slot retires.
- Any state to any state when a state word is written back.

The block also raises three protocol errors: an open while a run is active, a branch that is not in the final slot, and a narrow flag-setting instruction other than a comparison inside a run.

Top module: `pred_block_tracker`

## Requirements
- R1: After reset, `state_out` is 0, `active` and `last_slot` are low, and `exec_ok` is high.
- R2: When `open_vld` is high while idle, the next-cycle `state_out` is {`open_cond`, mask}. The mask holds the condition low bit of slots 2..N in bits 3 downward, then a 1, then zeros (N = `open_len`+1; N=1 gives 1000, N=4 gives {b2,b3,b4,1}).
- R3: While active, `exec_ok` equals the current condition evaluated on `flags_nzcv` (bit 3 N, bit 2 Z, bit 1 C, bit 0 V). The codes are: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V).
- R4: Slot 1 uses the base condition. Slot k+1 (k=1..3) uses the base condition with its low bit inverted when `open_sel[k-1]` is 1 (else) and unchanged when it is 0 (then).
- R5: Each `retire` while active moves to the next slot. After N retires, `active` is low and `state_out` is 0.
- R6: While idle, `exec_ok` is 1 and `retire` leaves `state_out` at 0.
- R7: `open_vld` while active raises `open_err` in that cycle and is ignored. The state changes only through a `retire` in the same cycle.
- R8: `restore_vld` loads `restore_state` into the state, taking priority over open and retire. A restored mask of 0 leaves the block idle with `state_out` 0. A restored run continues exactly as the saved one would.
- R9: `branch_err` is high when `retire` and `ins_branch` are both high while active in a slot that is not the final one.
- R10: `flag_err` is high when `retire`, `ins_narrow` and `ins_sets_flags` are all high and `ins_cmp` is low while active.
- R11: Codes 14 and 15 always pass, so an else slot under base code 14 also executes.
- R12: `last_slot` is high exactly when a run is active and the current slot is its final one (mask 1000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| open_vld | input | 1 | An if-then instruction opens a run |
| open_cond | input | 4 | Base condition code |
| open_sel | input | 3 | Per-slot else select for slots 2..4 (1 = else) |
| open_len | input | 2 | Instruction count minus one |
| retire | input | 1 | An instruction in the current slot retires |
| ins_branch | input | 1 | Retiring instruction is a branch |
| ins_narrow | input | 1 | Retiring instruction is a 16-bit encoding |
| ins_sets_flags | input | 1 | Retiring instruction writes the flags |
| ins_cmp | input | 1 | Retiring instruction is a comparison |
| flags_nzcv | input | 4 | Current condition flags |
| restore_vld | input | 1 | Write the saved state back |
| restore_state | input | 8 | State word to write |
| state_out | output | 8 | Current state word {condition, mask} |
| active | output | 1 | A run is in progress |
| last_slot | output | 1 | Current slot is the final one |
| exec_ok | output | 1 | Current instruction should execute |
| open_err | output | 1 | Open attempted during an active run |
| branch_err | output | 1 | Branch outside the final slot |
| flag_err | output | 1 | Narrow non-compare flag update inside a run |

## Verification
The checker watches several rules on every cycle:
- An idle block reads zero and always executes.
- An accepted open shows its base condition on the next cycle.
- Retiring the final slot closes the run.
- An open rejected during a run leaves the word unchanged.
- A write-back lands on the next cycle.
- The error outputs fire only in legal contexts.

Some behaviour only the bench scenarios can show: the full mask encoding for every length and then/else pattern, the per-code flag evaluation, and the resumption of a run after a mid-run save and restore. The bench exposes these by comparing every output against a slot-list model on each cycle, under random and directed sequences.

// File: rtl/pred_pkg.sv
`timescale 1ns/1ps
package pred_pkg;
    localparam int COND_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_LAST = 2'd2
    } blk_state_e;

    // condition pairs selected by the upper three code bits
    typedef enum logic [2:0] {
        CP_EQ = 3'd0,
        CP_CS = 3'd1,
        CP_MI = 3'd2,
        CP_VS = 3'd3,
        CP_HI = 3'd4,
        CP_GE = 3'd5,
        CP_GT = 3'd6,
        CP_AL = 3'd7
    } cond_pair_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;
endpackage

// File: rtl/pred_cond_eval.sv
`timescale 1ns/1ps
module pred_cond_eval
    import pred_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  logic [3:0]        nzcv,
    output logic              pass
);
    flags_t     fl;
    cond_pair_e pair;
    logic       raw;

    always_comb begin
        fl   = flags_t'(nzcv);
        pair = cond_pair_e'(cond[COND_W-1:1]);
        raw  = 1'b1;
        unique case (pair)
            CP_EQ:   raw = fl.z;
            CP_CS:   raw = fl.c;
            CP_MI:   raw = fl.n;
            CP_VS:   raw = fl.v;
            CP_HI:   raw = fl.c & ~fl.z;
            CP_GE:   raw = (fl.n == fl.v);
            CP_GT:   raw = ~fl.z & (fl.n == fl.v);
            CP_AL:   raw = 1'b1;
            default: raw = 1'b1;
        endcase
        // the low code bit inverts every pair except the always pair
        pass = (pair == CP_AL) ? 1'b1 : (raw ^ cond[0]);
    end
endmodule

// File: rtl/pred_mask_build.sv
`timescale 1ns/1ps
module pred_mask_build #(
    parameter int MAX_SLOTS = 4,
    parameter int LEN_W     = $clog2(MAX_SLOTS)
) (
    input  logic                 base_lsb,
    input  logic [MAX_SLOTS-2:0] sel,
    input  logic [LEN_W-1:0]     len,
    output logic [MAX_SLOTS-1:0] mask
);
    // slot k+2 sits at bit MAX_SLOTS-1-k; the terminator follows the last slot
    for (genvar k = 0; k < MAX_SLOTS; k++) begin : g_bit
        if (k < MAX_SLOTS - 1) begin : g_slot
            assign mask[MAX_SLOTS-1-k] = (LEN_W'(k) < len)  ? (base_lsb ^ sel[k])
                                                            : (LEN_W'(k) == len);
        end else begin : g_tail
            assign mask[0] = (len == LEN_W'(MAX_SLOTS - 1));
        end
    end
endmodule

// File: rtl/pred_seq.sv
`timescale 1ns/1ps
module pred_seq
    import pred_pkg::*;
#(
    parameter int MAX_SLOTS = 4,
    parameter int SW        = COND_W + MAX_SLOTS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restore_vld,
    input  logic [SW-1:0]        restore_state,
    input  logic                 load,
    input  logic [COND_W-1:0]    load_cond,
    input  logic [MAX_SLOTS-1:0] load_mask,
    input  logic                 advance,
    output logic [COND_W-1:0]    cond_q,
    output logic [MAX_SLOTS-1:0] mask_q,
    output logic                 is_active,
    output logic                 is_last
);
    localparam logic [MAX_SLOTS-1:0] LAST_MASK = {1'b1, {(MAX_SLOTS-1){1'b0}}};
    localparam logic [MAX_SLOTS-1:0] NO_MASK   = '0;

    blk_state_e           st_q, st_d;
    logic [COND_W-1:0]    cond_d;
    logic [MAX_SLOTS-1:0] mask_d;

    // next-state logic
    always_comb begin
        cond_d = cond_q;
        mask_d = mask_q;
        if (restore_vld) begin
            if (restore_state[MAX_SLOTS-1:0] == NO_MASK) begin
                cond_d = '0;
                mask_d = '0;
            end else begin
                cond_d = restore_state[SW-1:MAX_SLOTS];
                mask_d = restore_state[MAX_SLOTS-1:0];
            end
        end else if (load) begin
            cond_d = load_cond;
            mask_d = load_mask;
        end else if (advance) begin
            unique case (st_q)
                ST_LAST: begin
                    cond_d = '0;
                    mask_d = '0;
                end
                ST_RUN: begin
                    cond_d = {cond_q[COND_W-1:1], mask_q[MAX_SLOTS-1]};
                    mask_d = mask_q << 1;
                end
                default: begin
                    cond_d = cond_q;
                    mask_d = mask_q;
                end
            endcase
        end

        if (mask_d == NO_MASK)        st_d = ST_IDLE;
        else if (mask_d == LAST_MASK) st_d = ST_LAST;
        else                          st_d = ST_RUN;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cond_q <= '0;
            mask_q <= '0;
        end else begin
            st_q   <= st_d;
            cond_q <= cond_d;
            mask_q <= mask_d;
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            ST_IDLE: begin is_active = 1'b0; is_last = 1'b0; end
            ST_RUN:  begin is_active = 1'b1; is_last = 1'b0; end
            ST_LAST: begin is_active = 1'b1; is_last = 1'b1; end
            default: begin is_active = 1'b0; is_last = 1'b0; end
        endcase
    end
endmodule

// File: rtl/pred_block_tracker.sv
`timescale 1ns/1ps
module pred_block_tracker
    import pred_pkg::*;
#(
    parameter int MAX_SLOTS = 4,
    parameter int LEN_W     = $clog2(MAX_SLOTS),
    parameter int SW        = COND_W + MAX_SLOTS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 open_vld,
    input  logic [COND_W-1:0]    open_cond,
    input  logic [MAX_SLOTS-2:0] open_sel,
    input  logic [LEN_W-1:0]     open_len,
    input  logic                 retire,
    input  logic                 ins_branch,
    input  logic                 ins_narrow,
    input  logic                 ins_sets_flags,
    input  logic                 ins_cmp,
    input  logic [3:0]           flags_nzcv,
    input  logic                 restore_vld,
    input  logic [SW-1:0]        restore_state,
    output logic [SW-1:0]        state_out,
    output logic                 active,
    output logic                 last_slot,
    output logic                 exec_ok,
    output logic                 open_err,
    output logic                 branch_err,
    output logic                 flag_err
);
    logic [MAX_SLOTS-1:0] new_mask;
    logic [COND_W-1:0]    cur_cond;
    logic [MAX_SLOTS-1:0] cur_mask;
    logic                 cond_pass;
    logic                 load;
    logic                 advance;

    pred_mask_build #(.MAX_SLOTS(MAX_SLOTS), .LEN_W(LEN_W)) u_mask (
        .base_lsb (open_cond[0]),
        .sel      (open_sel),
        .len      (open_len),
        .mask     (new_mask)
    );

    assign load    = open_vld & ~active;
    assign advance = retire & active;

    pred_seq #(.MAX_SLOTS(MAX_SLOTS), .SW(SW)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .restore_vld   (restore_vld),
        .restore_state (restore_state),
        .load          (load),
        .load_cond     (open_cond),
        .load_mask     (new_mask),
        .advance       (advance),
        .cond_q        (cur_cond),
        .mask_q        (cur_mask),
        .is_active     (active),
        .is_last       (last_slot)
    );

    pred_cond_eval u_eval (
        .cond (cur_cond),
        .nzcv (flags_nzcv),
        .pass (cond_pass)
    );

    assign state_out  = {cur_cond, cur_mask};
    assign exec_ok    = ~active | cond_pass;
    assign open_err   = open_vld & active;
    assign branch_err = advance & ins_branch & ~last_slot;
    assign flag_err   = advance & ins_narrow & ins_sets_flags & ~ins_cmp;
endmodule

// File: rtl/pred_block_tracker_chk.sv
`timescale 1ns/1ps
module pred_block_tracker_chk #(
    parameter int MAX_SLOTS = 4,
    parameter int CW        = 4,
    parameter int SW        = CW + MAX_SLOTS
) (
    input logic          clk,
    input logic          rst_n,
    input logic          open_vld,
    input logic [CW-1:0] open_cond,
    input logic          retire,
    input logic          restore_vld,
    input logic [SW-1:0] restore_state,
    input logic [SW-1:0] state_out,
    input logic          active,
    input logic          last_slot,
    input logic          exec_ok,
    input logic          open_err,
    input logic          branch_err,
    input logic          flag_err
);
    localparam logic [MAX_SLOTS-1:0] LAST_MASK = {1'b1, {(MAX_SLOTS-1){1'b0}}};

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (state_out == '0) && exec_ok);

    // R2
    open_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_vld && !active && !restore_vld) |=> active && (state_out[SW-1:MAX_SLOTS] == $past(open_cond)));

    // R5
    final_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && last_slot && !restore_vld) |=> !active);

    // R7
    open_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_vld && active && !retire && !restore_vld) |=> $stable(state_out));

    // R7
    open_err_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_err |-> active && open_vld);

    // R8
    restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_vld |=> state_out == (($past(restore_state[MAX_SLOTS-1:0]) == '0) ? '0 : $past(restore_state)));

    // R9
    branch_err_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        branch_err |-> active && retire && !last_slot);

    // R10
    flag_err_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_err |-> active && retire);

    // R12
    last_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_slot |-> active && (state_out[MAX_SLOTS-1:0] == LAST_MASK));
endmodule

bind pred_block_tracker pred_block_tracker_chk #(.MAX_SLOTS(MAX_SLOTS), .CW(pred_pkg::COND_W), .SW(SW)) i_chk (.*);

// File: tb/test_pred_block_tracker.sv
`timescale 1ns/1ps
module test_pred_block_tracker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       open_vld = 0, retire = 0, ins_branch = 0, ins_narrow = 0;
    logic       ins_sets_flags = 0, ins_cmp = 0, restore_vld = 0;
    logic [3:0] open_cond = 0, flags_nzcv = 0;
    logic [2:0] open_sel = 0;
    logic [1:0] open_len = 0;
    logic [7:0] restore_state = 0;
    logic [7:0] state_out;
    logic       active, last_slot, exec_ok, open_err, branch_err, flag_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model: remaining slot conditions
    int         rem = 0;
    logic [3:0] sc [4];
    string      st_tag = "R1";

    always #10 clk = ~clk;

    pred_block_tracker i_pred_block_tracker (.*);

    function automatic logic holds(logic [3:0] c, logic [3:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return cy;
            4'd3:  return !cy;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return cy && !z;
            4'd9:  return !cy || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] exp_state();
        logic [3:0] m = 4'd0;
        if (rem == 0) return 8'd0;
        for (int i = 1; i < rem; i++) m[4-i] = sc[i][0];
        m[4-rem] = 1'b1;
        return {sc[0], m};
    endfunction

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic drive(logic ov, logic [3:0] oc, logic [2:0] os, logic [1:0] ol,
                         logic rt, logic br, logic na, logic sf, logic cm,
                         logic [3:0] fl, logic rv, logic [7:0] rs);
        open_vld = ov; open_cond = oc; open_sel = os; open_len = ol;
        retire = rt; ins_branch = br; ins_narrow = na; ins_sets_flags = sf; ins_cmp = cm;
        flags_nzcv = fl; restore_vld = rv; restore_state = rs;
    endtask

    // compare combinational outputs, then clock and update the model
    task automatic step();
        logic act;
        #2;
        act = (rem > 0);
        chk(st_tag, state_out, exp_state());
        chk("R5 active", {7'd0, active}, {7'd0, act});
        chk("R12 last_slot", {7'd0, last_slot}, {7'd0, rem == 1});
        chk(act ? "R3 R4 R11 exec_ok" : "R6 exec_ok", {7'd0, exec_ok},
            {7'd0, !act || holds(sc[0], flags_nzcv)});
        chk("R7 open_err", {7'd0, open_err}, {7'd0, open_vld && act});
        chk("R9 branch_err", {7'd0, branch_err}, {7'd0, retire && act && ins_branch && rem > 1});
        chk("R10 flag_err", {7'd0, flag_err},
            {7'd0, retire && act && ins_narrow && ins_sets_flags && !ins_cmp});
        @(posedge clk);
        if (restore_vld) begin
            st_tag = "R8 state";
            rem = 0;
            for (int j = 3; j >= 0; j--) if (restore_state[j]) rem = 4 - j;
            sc[0] = restore_state[7:4];
            for (int i = 1; i < 4; i++) sc[i] = {restore_state[7:5], restore_state[4-i]};
        end else if (open_vld && !act) begin
            st_tag = "R2 state";
            rem = open_len + 1;
            sc[0] = open_cond;
            for (int i = 1; i < 4; i++) sc[i] = {open_cond[3:1], open_cond[0] ^ open_sel[i-1]};
        end else if (retire && act) begin
            st_tag = "R5 state";
            for (int i = 0; i < 3; i++) sc[i] = sc[i+1];
            rem--;
        end else begin
            st_tag = open_vld ? "R7 state" : "R6 state";
        end
        @(negedge clk);
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] f;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) sc[i] = 4'd0;
        repeat (3) @(negedge clk);
        // R1: reset state visible before release
        chk("R1 reset state", state_out, 8'd0);
        chk("R1 reset exec_ok", {7'd0, exec_ok}, 8'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R4: four slots, then/else/then on base EQ, Z set
        drive(1, 4'd0, 3'b010, 2'd3, 0, 0, 0, 0, 0, 4'b0100, 0, 8'd0); step();
        for (int k = 0; k < 4; k++) begin
            drive(0, 0, 0, 0, 1, k == 3, 0, 0, 0, 4'b0100, 0, 8'd0); step();
        end
        // R9: branch in first slot of two
        drive(1, 4'd10, 3'b001, 2'd1, 0, 0, 0, 0, 0, 4'b1001, 0, 8'd0); step();
        drive(0, 0, 0, 0, 1, 1, 0, 0, 0, 4'b1001, 0, 8'd0); step();
        drive(0, 0, 0, 0, 1, 1, 0, 0, 0, 4'b1000, 0, 8'd0); step();
        // R11: base 14 with else slot executes
        drive(1, 4'd14, 3'b001, 2'd1, 0, 0, 0, 0, 0, 4'b0000, 0, 8'd0); step();
        drive(0, 0, 0, 0, 1, 0, 0, 0, 0, 4'b0000, 0, 8'd0); step();
        drive(0, 0, 0, 0, 1, 0, 0, 0, 0, 4'b1111, 0, 8'd0); step();
        // R7 R10: open during run, narrow flag writer
        drive(1, 4'd2, 3'b000, 2'd2, 0, 0, 0, 0, 0, 4'b0010, 0, 8'd0); step();
        drive(1, 4'd5, 3'b111, 2'd0, 0, 0, 1, 1, 0, 4'b0010, 0, 8'd0); step();
        drive(0, 0, 0, 0, 1, 0, 1, 1, 1, 4'b0010, 0, 8'd0); step();
        // R8: save mid-run, clear, restore, resume
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h00); step();
        drive(0, 0, 0, 0, 1, 0, 0, 0, 0, 4'b0000, 0, 8'd0); step();
        drive(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 1, 8'hB6); step();
        drive(0, 0, 0, 0, 1, 0, 0, 0, 0, 4'b0001, 0, 8'd0); step();
        drive(0, 0, 0, 0, 1, 0, 0, 0, 0, 4'b0110, 0, 8'd0); step();
        drive(0, 0, 0, 0, 1, 0, 0, 0, 0, 4'b0110, 0, 8'd0); step();

        // constrained random
        for (int n = 0; n < 3000; n++) begin
            int r = $urandom_range(99);
            f = 4'($urandom);
            if (r < 4)
                drive(0, 0, 0, 0, $urandom_range(1), 0, 0, 0, 0, f, 1,
                      ($urandom_range(3) == 0) ? {4'($urandom), 4'd0} : 8'($urandom));
            else if (r < 30)
                drive(1, 4'($urandom), 3'($urandom), 2'($urandom), $urandom_range(1),
                      $urandom_range(1), $urandom_range(1), $urandom_range(1),
                      $urandom_range(1), f, 0, 8'd0);
            else if (r < 85)
                drive(0, 0, 0, 0, 1, $urandom_range(3) == 0, $urandom_range(1),
                      $urandom_range(1), $urandom_range(1), f, 0, 8'd0);
            else
                drive(0, 0, 0, 0, 0, 0, 0, 0, 0, f, 0, 8'd0);
            step();
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule